// File: doc/BRIEF.md
# Block-Stride Page Transfer Engine

This engine moves one management page of data at a time between external memory and an on-chip scratchpad. A command carries an external base address, a block length, a stride between block starts, a block count, a scratchpad start address and a direction.

In the load direction, the engine gathers blocks that lie apart in external memory and packs them back to back into a contiguous scratchpad area. In the store direction, it reads a contiguous scratchpad area and scatters it into the same strided block pattern. All addresses and lengths are counted in 8-byte words. A management page of 4 KB is therefore 512 words. The external port carries one word per request.

The block takes one command at a time and applies backpressure while that command runs. Core loads and stores present their scratchpad address on a hazard port. The engine asks them to wait while that address lies inside the scratchpad window of the running transfer. At the start of each external block, the engine raises a one-cycle coherence notice carrying the block's external address and length, so the data cache can perform its consistency action.

Top module: `page_xfer_engine`

## Requirements
- R1: After reset the engine is idle: `busy`=0, `done`=0, `cmd_ready`=1, and no external request and no scratchpad read or write is asserted.
- R2: In a load (`cmd_store`=0), beat k requests external word `ext_base + (k / blk_len)*stride + (k mod blk_len)`. The returned word is written to scratchpad word `(sp_base + k) mod 4096` in the same cycle as its response.
- R3: In a store (`cmd_store`=1), beat k reads scratchpad word `(sp_base + k) mod 4096`. That value is written to external word `ext_base + (k / blk_len)*stride + (k mod blk_len)`, and beats are issued in increasing k.
- R4: At most one external request is outstanding. A request held without `ext_req_ready` keeps its address and data stable. After acceptance, no new request is raised until the response (read data or write acknowledge) has arrived.
- R5: `done` is high for exactly one cycle: the cycle after the final beat's response. `busy` is low in that cycle.
- R6: A command whose block count or block length is zero raises `done` in the cycle after acceptance and makes no external or scratchpad access.
- R7: `cmd_ready` is low while a command runs, so a further command is held off until the running one has finished.
- R8: The number of beats is `min(blk_len*blk_cnt, 512)`. A pattern longer than one page stops after 512 words.
- R9: `hz_stall` is high exactly when `busy`=1, `hz_valid`=1 and `(hz_addr - sp_base) mod 4096` is below the transfer's beat count.
- R10: `coh_valid` pulses for one cycle at the start of each external block, no later than that block's first external request. It carries the block's start address on `coh_addr` and the block length on `coh_len`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command taken this cycle when high with cmd_valid |
| cmd_store | input | 1 | 0 = page load, 1 = page store |
| cmd_ext_base | input | 32 | External word address of the first block |
| cmd_blk_len | input | 10 | Words per block |
| cmd_stride | input | 32 | Words between consecutive block starts |
| cmd_blk_cnt | input | 10 | Number of blocks |
| cmd_sp_base | input | 12 | Scratchpad start word |
| busy | output | 1 | A command is running |
| done | output | 1 | One-cycle completion pulse |
| ext_req_valid | output | 1 | External request |
| ext_req_ready | input | 1 | External request accepted |
| ext_req_write | output | 1 | 1 = write request, 0 = read request |
| ext_req_addr | output | 32 | External word address |
| ext_req_wdata | output | 64 | Write data |
| ext_rsp_valid | input | 1 | Read data valid or write acknowledge |
| ext_rsp_rdata | input | 64 | Read data |
| sp_we | output | 1 | Scratchpad write strobe |
| sp_re | output | 1 | Scratchpad read strobe (data one cycle later) |
| sp_addr | output | 12 | Scratchpad word address |
| sp_wdata | output | 64 | Scratchpad write data |
| sp_rdata | input | 64 | Scratchpad read data |
| hz_valid | input | 1 | Core scratchpad access present |
| hz_addr | input | 12 | Core scratchpad word address |
| hz_stall | output | 1 | Core access must wait |
| coh_valid | output | 1 | Coherence notice for one block |
| coh_addr | output | 32 | External start address of that block |
| coh_len | output | 10 | Length of that block in words |

## Verification
The gather and scatter paths are driven with a table of commands, and each command isolates a different kind of fault:
- Blocks wider than one word with gaps between them expose a wrong offset or stride step.
- Single-word blocks put a block boundary at every beat.
- Blocks whose stride equals their length form a contiguous run, which separates the block walk from the beat count.
- A scratchpad start near the top of the scratchpad exposes missing wrap-around.
- A pattern longer than one page exercises the page limit.

The external responder inserts periodic wait cycles, so request holding is exercised. Directed cases cover zero-count and zero-length commands, and probe hazard addresses just inside and just outside the transfer window.

// File: rtl/pxe_pkg.sv
package pxe_pkg;

    parameter int EXT_AW     = 32;
    parameter int SP_AW      = 12;
    parameter int LEN_W      = 10;
    parameter int CNT_W      = 10;
    parameter int DATA_W     = 64;
    parameter int PAGE_BEATS = 512;
    parameter int BEAT_W     = $clog2(PAGE_BEATS) + 1;
    parameter int PROD_W     = LEN_W + CNT_W;

    typedef logic [EXT_AW-1:0] ext_addr_t;
    typedef logic [SP_AW-1:0]  sp_addr_t;
    typedef logic [LEN_W-1:0]  len_t;
    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [DATA_W-1:0] word_t;
    typedef logic [BEAT_W-1:0] beat_t;

    typedef struct packed {
        logic      is_store;
        ext_addr_t ext_base;
        len_t      blk_len;
        ext_addr_t stride;
        cnt_t      blk_cnt;
        sp_addr_t  sp_base;
    } xfer_cmd_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SP_RD,
        ST_SP_LAT,
        ST_EXT_REQ,
        ST_EXT_WAIT
    } xfer_state_e;

    // Beats of a command, limited to one management page.
    function automatic beat_t page_clip(input len_t l, input cnt_t c);
        logic [PROD_W-1:0] p;
        p = PROD_W'(l) * PROD_W'(c);
        if (p > PROD_W'(PAGE_BEATS)) return BEAT_W'(PAGE_BEATS);
        return BEAT_W'(p);
    endfunction

    // Address inside [base, base+n) with wrap modulo scratchpad size.
    function automatic logic in_window(input sp_addr_t a, input sp_addr_t b, input beat_t n);
        sp_addr_t d;
        d = a - b;
        return 32'(d) < 32'(n);
    endfunction

endpackage

// File: rtl/pxe_walker.sv
module pxe_walker
    import pxe_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      load,
    input  xfer_cmd_t cmd,
    input  logic      step,
    output logic      zero_cmd,
    output ext_addr_t ext_addr,
    output sp_addr_t  sp_addr,
    output logic      last,
    output beat_t     total,
    output sp_addr_t  win_base,
    output logic      coh_valid,
    output ext_addr_t coh_addr,
    output len_t      coh_len
);

    xfer_cmd_t cur;
    ext_addr_t blk_base;
    len_t      off;
    beat_t     beat_cnt;
    beat_t     total_q;
    logic      coh_q;
    beat_t     new_total;
    logic      blk_end;

    assign new_total = page_clip(cmd.blk_len, cmd.blk_cnt);
    assign zero_cmd  = (new_total == '0);
    assign blk_end   = (off == cur.blk_len - LEN_W'(1));
    assign last      = (beat_cnt == total_q - BEAT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cur      <= '0;
            blk_base <= '0;
            off      <= '0;
            beat_cnt <= '0;
            total_q  <= '0;
            coh_q    <= 1'b0;
        end else begin
            coh_q <= 1'b0;
            if (load) begin
                cur      <= cmd;
                blk_base <= cmd.ext_base;
                off      <= '0;
                beat_cnt <= '0;
                total_q  <= new_total;
                coh_q    <= !zero_cmd;
            end else if (step) begin
                beat_cnt <= beat_cnt + BEAT_W'(1);
                if (blk_end) begin
                    off      <= '0;
                    blk_base <= blk_base + cur.stride;
                    coh_q    <= !last;
                end else begin
                    off <= off + LEN_W'(1);
                end
            end
        end
    end

    assign ext_addr  = blk_base + EXT_AW'(off);
    assign sp_addr   = cur.sp_base + SP_AW'(beat_cnt);
    assign total     = total_q;
    assign win_base  = cur.sp_base;
    assign coh_valid = coh_q;
    assign coh_addr  = blk_base;
    assign coh_len   = cur.blk_len;

endmodule

// File: rtl/pxe_guard.sv
module pxe_guard
    import pxe_pkg::*;
(
    input  logic     active,
    input  logic     hz_valid,
    input  sp_addr_t hz_addr,
    input  sp_addr_t win_base,
    input  beat_t    win_len,
    output logic     hz_stall
);

    assign hz_stall = active && hz_valid && in_window(hz_addr, win_base, win_len);

endmodule

// File: rtl/pxe_seq.sv
module pxe_seq
    import pxe_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  cmd_valid,
    input  logic  cmd_store,
    input  logic  zero_cmd,
    input  logic  last,
    input  logic  ext_req_ready,
    input  logic  ext_rsp_valid,
    input  word_t ext_rsp_rdata,
    input  word_t sp_rdata,
    output logic  cmd_ready,
    output logic  load,
    output logic  step,
    output logic  busy,
    output logic  done,
    output logic  ext_req_valid,
    output logic  ext_req_write,
    output word_t ext_req_wdata,
    output logic  sp_we,
    output logic  sp_re,
    output word_t sp_wdata
);

    xfer_state_e state;
    logic        store_q;
    logic        done_q;
    word_t       wbuf;

    always_comb begin
        cmd_ready     = (state == ST_IDLE);
        load          = cmd_ready && cmd_valid;
        busy          = (state != ST_IDLE);
        step          = 1'b0;
        ext_req_valid = 1'b0;
        sp_we         = 1'b0;
        sp_re         = 1'b0;
        case (state)
            ST_SP_RD:    sp_re = 1'b1;
            ST_EXT_REQ:  ext_req_valid = 1'b1;
            ST_EXT_WAIT: begin
                step  = ext_rsp_valid;
                sp_we = ext_rsp_valid && !store_q;
            end
            default: ;
        endcase
    end

    assign ext_req_write = store_q;
    assign ext_req_wdata = wbuf;
    assign sp_wdata      = ext_rsp_rdata;
    assign done          = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            store_q <= 1'b0;
            done_q  <= 1'b0;
            wbuf    <= '0;
        end else begin
            done_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (load) begin
                        store_q <= cmd_store;
                        if (zero_cmd) done_q <= 1'b1;
                        else state <= cmd_store ? ST_SP_RD : ST_EXT_REQ;
                    end
                end
                ST_SP_RD:  state <= ST_SP_LAT;
                ST_SP_LAT: begin
                    wbuf  <= sp_rdata;
                    state <= ST_EXT_REQ;
                end
                ST_EXT_REQ: begin
                    if (ext_req_ready) state <= ST_EXT_WAIT;
                end
                ST_EXT_WAIT: begin
                    if (ext_rsp_valid) begin
                        if (last) begin
                            state  <= ST_IDLE;
                            done_q <= 1'b1;
                        end else begin
                            state <= store_q ? ST_SP_RD : ST_EXT_REQ;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/page_xfer_engine.sv
module page_xfer_engine
    import pxe_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_store,
    input  logic [EXT_AW-1:0] cmd_ext_base,
    input  logic [LEN_W-1:0]  cmd_blk_len,
    input  logic [EXT_AW-1:0] cmd_stride,
    input  logic [CNT_W-1:0]  cmd_blk_cnt,
    input  logic [SP_AW-1:0]  cmd_sp_base,
    output logic              busy,
    output logic              done,
    output logic              ext_req_valid,
    input  logic              ext_req_ready,
    output logic              ext_req_write,
    output logic [EXT_AW-1:0] ext_req_addr,
    output logic [DATA_W-1:0] ext_req_wdata,
    input  logic              ext_rsp_valid,
    input  logic [DATA_W-1:0] ext_rsp_rdata,
    output logic              sp_we,
    output logic              sp_re,
    output logic [SP_AW-1:0]  sp_addr,
    output logic [DATA_W-1:0] sp_wdata,
    input  logic [DATA_W-1:0] sp_rdata,
    input  logic              hz_valid,
    input  logic [SP_AW-1:0]  hz_addr,
    output logic              hz_stall,
    output logic              coh_valid,
    output logic [EXT_AW-1:0] coh_addr,
    output logic [LEN_W-1:0]  coh_len
);

    xfer_cmd_t cmd;
    logic      load, step, zero_cmd, last;
    beat_t     total;
    sp_addr_t  win_base;

    assign cmd = '{is_store: cmd_store, ext_base: cmd_ext_base, blk_len: cmd_blk_len,
                   stride: cmd_stride, blk_cnt: cmd_blk_cnt, sp_base: cmd_sp_base};

    pxe_walker u_walker (
        .clk(clk), .rst(rst), .load(load), .cmd(cmd), .step(step),
        .zero_cmd(zero_cmd), .ext_addr(ext_req_addr), .sp_addr(sp_addr),
        .last(last), .total(total), .win_base(win_base),
        .coh_valid(coh_valid), .coh_addr(coh_addr), .coh_len(coh_len)
    );

    pxe_seq u_seq (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_store(cmd_store),
        .zero_cmd(zero_cmd), .last(last), .ext_req_ready(ext_req_ready),
        .ext_rsp_valid(ext_rsp_valid), .ext_rsp_rdata(ext_rsp_rdata),
        .sp_rdata(sp_rdata), .cmd_ready(cmd_ready), .load(load), .step(step),
        .busy(busy), .done(done), .ext_req_valid(ext_req_valid),
        .ext_req_write(ext_req_write), .ext_req_wdata(ext_req_wdata),
        .sp_we(sp_we), .sp_re(sp_re), .sp_wdata(sp_wdata)
    );

    pxe_guard u_guard (
        .active(busy), .hz_valid(hz_valid), .hz_addr(hz_addr),
        .win_base(win_base), .win_len(total), .hz_stall(hz_stall)
    );

endmodule

// File: rtl/pxe_chk.sv
module pxe_chk
    import pxe_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              done,
    input logic              cmd_ready,
    input logic              ext_req_valid,
    input logic              ext_req_ready,
    input logic [EXT_AW-1:0] ext_req_addr,
    input logic [DATA_W-1:0] ext_req_wdata,
    input logic              ext_rsp_valid,
    input logic              sp_we,
    input logic              sp_re,
    input logic              hz_stall,
    input logic              coh_valid
);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!ext_req_valid && !sp_we && !sp_re)); // R6
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (ext_req_valid && !ext_req_ready) |=> (ext_req_valid && $stable(ext_req_addr) && $stable(ext_req_wdata))); // R4
    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
        (ext_req_valid && ext_req_ready) |=> !ext_req_valid); // R4
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R5
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R5
    AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        busy |-> !cmd_ready); // R7
    AST_HAZ_IDLE: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !hz_stall); // R9
    AST_COH_PULSE: assert property (@(posedge clk) disable iff (rst)
        coh_valid |=> !coh_valid); // R10
    AST_SPWE_ON_RSP: assert property (@(posedge clk) disable iff (rst)
        sp_we |-> ext_rsp_valid); // R2

endmodule

bind page_xfer_engine pxe_chk i_pxe_chk (
    .clk(clk), .rst(rst), .busy(busy), .done(done), .cmd_ready(cmd_ready),
    .ext_req_valid(ext_req_valid), .ext_req_ready(ext_req_ready),
    .ext_req_addr(ext_req_addr), .ext_req_wdata(ext_req_wdata),
    .ext_rsp_valid(ext_rsp_valid), .sp_we(sp_we), .sp_re(sp_re),
    .hz_stall(hz_stall), .coh_valid(coh_valid)
);

// File: tb/test_page_xfer_engine.sv
module test_page_xfer_engine;

    localparam int PER = 10;
    localparam int NV  = 6;
    // store, ext_base, blk_len, stride, blk_cnt, sp_base, expected beats
    localparam int VTAB [NV][7] = '{
        '{0,  100,  4,  10,  3,    0,  12},
        '{0,  500,  1,   3,  7, 4090,   7},
        '{0, 2000, 16,  16,  2,  200,  32},
        '{1, 3000,  3,   8,  4,  300,  12},
        '{1, 1200,  2, 100,  5, 4094,  10},
        '{0,    0, 64,  64, 16, 1000, 512}
    };

    logic        clk = 0, rst = 1;
    logic        cmd_valid = 0, cmd_ready, cmd_store = 0;
    logic [31:0] cmd_ext_base = 0, cmd_stride = 0;
    logic [9:0]  cmd_blk_len = 0, cmd_blk_cnt = 0;
    logic [11:0] cmd_sp_base = 0;
    logic        busy, done;
    logic        ext_req_valid, ext_req_ready = 0, ext_req_write;
    logic [31:0] ext_req_addr;
    logic [63:0] ext_req_wdata, ext_rsp_rdata = 0;
    logic        ext_rsp_valid = 0;
    logic        sp_we, sp_re;
    logic [11:0] sp_addr;
    logic [63:0] sp_wdata, sp_rdata = 0;
    logic        hz_valid = 0, hz_stall;
    logic [11:0] hz_addr = 0;
    logic        coh_valid;
    logic [31:0] coh_addr;
    logic [9:0]  coh_len;

    page_xfer_engine i_page_xfer_engine (.*);

    always #(PER/2) clk = ~clk;

    int total = 0, bad = 0;
    logic [63:0] sp_mem [4096];
    logic [63:0] ext_wr [4096];
    int log_addr [1024];
    int log_n = 0, sp_we_n = 0, sp_re_n = 0, coh_n = 0, coh_bad = 0;
    int tick = 0;
    bit acc_pend = 0, rd_pend = 0, acc_write = 0;
    logic [31:0] acc_addr;
    logic [11:0] rd_addr;
    int cur_base = 0, cur_stride = 0, cur_len = 1;

    function automatic logic [63:0] ext_pat(input logic [31:0] a);
        return {a ^ 32'h5A5A0000, ~a};
    endfunction
    function automatic logic [63:0] sp_pat(input int k);
        return {32'hC0DE0000 + k, 32'(k * 7)};
    endfunction
    function automatic int exp_ext(input int base, input int len, input int stride, input int k);
        return base + (k / len) * stride + (k % len);
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // External memory and scratchpad models: drive after negedge, sample 1 later.
    always begin
        @(negedge clk);
        ext_rsp_valid = acc_pend;
        if (acc_pend && !acc_write) ext_rsp_rdata = ext_pat(acc_addr);
        acc_pend = 0;
        if (rd_pend) sp_rdata = sp_mem[rd_addr];
        rd_pend = 0;
        ext_req_ready = (tick % 3) != 2;
        tick++;
        #1;
        if (ext_req_valid && ext_req_ready) begin
            if (log_n < 1024) log_addr[log_n] = int'(ext_req_addr);
            log_n++;
            if (ext_req_write) ext_wr[ext_req_addr[11:0]] = ext_req_wdata;
            acc_pend = 1; acc_write = ext_req_write; acc_addr = ext_req_addr;
        end
        if (sp_we) begin sp_mem[sp_addr] = sp_wdata; sp_we_n++; end
        if (sp_re) begin rd_pend = 1; rd_addr = sp_addr; sp_re_n++; end
        if (coh_valid) begin
            if (int'(coh_addr) != cur_base + coh_n * cur_stride || int'(coh_len) != cur_len) coh_bad++;
            coh_n++;
        end
    end

    task automatic clear_logs();
        log_n = 0; sp_we_n = 0; sp_re_n = 0; coh_n = 0; coh_bad = 0;
    endtask

    task automatic issue(input bit st, input int base, input int len, input int stride,
                         input int cnt, input int sp);
        cur_base = base; cur_stride = stride; cur_len = len;
        @(negedge clk);
        cmd_store = st; cmd_ext_base = 32'(base); cmd_blk_len = 10'(len);
        cmd_stride = 32'(stride); cmd_blk_cnt = 10'(cnt); cmd_sp_base = 12'(sp);
        cmd_valid = 1;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 0;
        #1;
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done && n < 20000) begin @(negedge clk); #1; n++; end
        chk(done, "R5 done timeout", done, 1);
    endtask

    initial begin
        #(PER * 150000);
        bad++; total++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(!busy && !done && cmd_ready, "R1 idle flags", {busy, done, cmd_ready}, 1);
        chk(!ext_req_valid && !sp_we && !sp_re, "R1 no access", {ext_req_valid, sp_we, sp_re}, 0);
        @(negedge clk); rst = 0;

        for (int v = 0; v < NV; v++) begin
            int st = VTAB[v][0], b = VTAB[v][1], l = VTAB[v][2], s = VTAB[v][3];
            int c = VTAB[v][4], sp = VTAB[v][5], e = VTAB[v][6];
            int bad_ord = 0, bad_dat = 0;
            if (st == 1) for (int k = 0; k < 4096; k++) sp_mem[k] = sp_pat(k);
            clear_logs();
            issue(st[0], b, l, s, c, sp);
            wait_done();
            chk(log_n == e, (e == 512) ? "R8 page cap beats" : "R2/R3 beat count", log_n, e);
            for (int k = 0; k < e && k < 1024; k++)
                if (log_addr[k] != exp_ext(b, l, s, k)) bad_ord++;
            chk(bad_ord == 0, st ? "R3 scatter order" : "R2 gather order", bad_ord, 0);
            for (int k = 0; k < e; k++) begin
                int spa = (sp + k) % 4096;
                int ea = exp_ext(b, l, s, k);
                if (st == 0) begin
                    if (sp_mem[spa] != ext_pat(32'(ea))) bad_dat++;
                end else begin
                    if (ext_wr[ea % 4096] != sp_pat(spa)) bad_dat++;
                end
            end
            chk(bad_dat == 0, st ? "R3 store data" : "R2 load data", bad_dat, 0);
            chk(coh_n == (e + l - 1) / l && coh_bad == 0, "R10 coherence notices", coh_n, (e + l - 1) / l);
        end

        // Zero block count, then zero block length (R6).
        clear_logs();
        issue(0, 64, 4, 8, 0, 10);
        chk(done == 1, "R6 zero count done", done, 1);
        @(negedge clk); #1;
        chk(done == 0, "R5 single pulse", done, 0);
        repeat (3) @(negedge clk);
        chk(log_n + sp_we_n + sp_re_n + coh_n == 0, "R6 zero count no access", log_n + sp_we_n + sp_re_n, 0);
        clear_logs();
        issue(1, 64, 0, 8, 5, 10);
        chk(done == 1, "R6 zero length done", done, 1);
        repeat (3) @(negedge clk);
        chk(log_n + sp_we_n + sp_re_n + coh_n == 0, "R6 zero length no access", log_n + sp_we_n + sp_re_n, 0);

        // Hazard window and backpressure while busy (R7, R9).
        clear_logs();
        issue(0, 0, 4, 8, 4, 100);
        chk(busy && !cmd_ready, "R7 busy blocks commands", cmd_ready, 0);
        hz_valid = 1; hz_addr = 100; #1;
        chk(hz_stall == 1, "R9 window start", hz_stall, 1);
        @(negedge clk); hz_addr = 115; #1;
        chk(hz_stall == 1, "R9 window end", hz_stall, 1);
        @(negedge clk); hz_addr = 116; #1;
        chk(hz_stall == 0, "R9 past window", hz_stall, 0);
        @(negedge clk); hz_addr = 99; #1;
        chk(hz_stall == 0, "R9 below window", hz_stall, 0);
        @(negedge clk); hz_valid = 0; hz_addr = 105; #1;
        chk(hz_stall == 0, "R9 no request", hz_stall, 0);
        wait_done();
        hz_valid = 1; hz_addr = 105; #1;
        chk(hz_stall == 0, "R9 idle no stall", hz_stall, 0);
        hz_valid = 0;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule